// File: doc/BRIEF.md
# Scanline Position Interrupt Generator

This block watches a raster that is already running elsewhere on the chip: a physical line counter, a dot counter within the line and a field flag. It raises single-clock interrupt pulses when the raster reaches positions that software has set. Two vertical comparators each fire at dot zero of their own target line. A third comparator fires at a set line and a set dot offset within that line. It can fire once per field, every N field lines, or on every field line.

Programmed line numbers count lines within one field. A programmed line n therefore matches physical line 2n while the field flag shows an even field, and physical line 2n+1 while it shows an odd field. A target whose doubled value reaches the frame's total line count is never matched. In the repeating modes the horizontal target moves forward after each hit. It wraps by subtracting half the total line count, and the wrap takes a few clocks, during which that comparator is held off. Registers are written over a simple address/data bus. Combining the outputs into a system interrupt is left to a controller outside this block.

Top module: `scanirq_gen`

## Requirements
- R1: Writing address 0 loads vertical target A from data bits [25:16] and vertical target B from bits [9:0]. Target A drives `irq_va_o` and target B drives `irq_vb_o`. All other data bits are ignored.
- R2: A vertical output pulses when the raster shows dot 0 on physical line 2n+f, where n is its target and f is `odd_field_i` (1 = odd field).
- R3: A target n with 2n not below `frame_lines_i` never fires. This applies to both vertical targets and to the horizontal target.
- R4: Writing address 1 loads the horizontal setting: line field in bits [9:0], mode in bits [13:12] and dot offset in bits [25:16]. Bits outside mask 0x03FF33FF are ignored.
- R5: The horizontal output fires on its target line at dot 2×offset. If 2×offset is greater than `last_dot_i`, it fires at dot `last_dot_i` instead.
- R6: In modes 0 and 3 the horizontal target is the line field itself, and it fires once in every field whose physical line exists.
- R7: In mode 1, with N the line field, the write sets the target to (current physical line ÷ 2) + N, wrapped. After each hit the target advances by N, wrapped.
- R8: Mode 2 behaves as mode 1 with N = 1, whatever the line field holds.
- R9: A wrap subtracts half of `frame_lines_i`, rounded down, until the target is no longer greater than that half. While the wrap is in progress the horizontal comparator cannot fire.
- R10: Every output is a pulse one clock long. It is registered one clock after the matching raster position is presented. A raster held on the same matching position does not produce a second pulse.
- R11: A write in the same cycle as a match does not suppress that cycle's pulse. The written values take effect from the next cycle, and the write replaces any advance the hit would have caused.
- R12: While reset is held, all outputs are low. After reset, both vertical targets and the horizontal line, mode and offset are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 = vertical targets, 1 = horizontal setting |
| wr_data | input | 32 | Register write data |
| line_i | input | FLD_W+1 | Current physical raster line |
| dot_i | input | DOT_W | Current dot within the line |
| odd_field_i | input | 1 | Field flag, 1 = odd field |
| frame_lines_i | input | FLD_W+1 | Total physical lines per frame (static) |
| last_dot_i | input | DOT_W | Index of the last dot in a line (static) |
| irq_va_o | output | 1 | Pulse for vertical target A |
| irq_vb_o | output | 1 | Pulse for vertical target B |
| irq_h_o | output | 1 | Pulse for the horizontal target |

## Verification
A register write and a comparator hit can land in the same clock. The repeating horizontal mode is where this matters most, because the hit wants to advance the target while the write wants to replace it. The bench drives a write into exactly the cycle its arithmetic model predicts a horizontal hit, and does the same for a vertical hit. It expects the pulse computed from the old setting, and from the next cycle it expects the positions of the newly written setting only. The offset sweep with clamping also lets hits fall on the last dot, which is the very cycle in which each new setting is written, so that collision is covered across many settings as well.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

  // Horizontal comparator repeat selection, encoded as written in bits [13:12].
  typedef enum logic [1:0] {
    HM_FRAME      = 2'd0,
    HM_EVERY_N    = 2'd1,
    HM_EVERY_LINE = 2'd2,
    HM_FRAME_ALT  = 2'd3
  } hmode_e;

  localparam logic [31:0] VREG_MASK = 32'h03FF_03FF;
  localparam logic [31:0] HREG_MASK = 32'h03FF_33FF;

  function automatic logic is_repeat(input hmode_e m);
    return (m == HM_EVERY_N) || (m == HM_EVERY_LINE);
  endfunction

endpackage

// File: rtl/scanirq_regs.sv
module scanirq_regs
  import scanirq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int V_ADDR = 0,
  parameter int H_ADDR = 1,
  parameter int FLD_W  = 10,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [FLD_W-1:0]  va_o,
  output logic [FLD_W-1:0]  vb_o,
  output logic [OFF_W-1:0]  hoff_o,
  output logic              h_load_o,
  output logic [FLD_W-1:0]  h_line_o,
  output hmode_e            h_mode_o
);

  logic [31:0]      v_data, h_data;
  logic             v_hit, h_hit;
  logic [FLD_W-1:0] va_q, vb_q, va_d, vb_d;
  logic [OFF_W-1:0] hoff_q, hoff_d;

  assign v_hit  = wr_en && (wr_addr == ADDR_W'(V_ADDR));
  assign h_hit  = wr_en && (wr_addr == ADDR_W'(H_ADDR));
  assign v_data = wr_data & VREG_MASK;
  assign h_data = wr_data & HREG_MASK;

  always_comb begin
    va_d   = v_data[16 +: FLD_W];
    vb_d   = v_data[0 +: FLD_W];
    hoff_d = h_data[16 +: OFF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q <= '0;
      vb_q <= '0;
    end else if (v_hit) begin
      va_q <= va_d;
      vb_q <= vb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hoff_q <= '0;
    else if (h_hit) hoff_q <= hoff_d;
  end

  assign va_o     = va_q;
  assign vb_o     = vb_q;
  assign hoff_o   = hoff_q;
  assign h_load_o = h_hit;
  assign h_line_o = h_data[0 +: FLD_W];
  assign h_mode_o = hmode_e'(h_data[13:12]);

  // R1: a vertical write lands both fields from their bit positions
  p_vwrite_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && (wr_addr == ADDR_W'(V_ADDR))) |->
      (va_o == $past(wr_data[16 +: FLD_W])) && (vb_o == $past(wr_data[0 +: FLD_W])));

  // R4: the offset register moves only on a horizontal write
  p_hoff_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && (wr_addr == ADDR_W'(H_ADDR))) |-> $stable(hoff_o));

endmodule

// File: rtl/scanirq_vcmp.sv
module scanirq_vcmp #(
  parameter int FLD_W = 10,
  parameter int DOT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLD_W-1:0] tgt_i,
  input  logic [FLD_W:0]   line_i,
  input  logic [DOT_W-1:0] dot_i,
  input  logic             odd_i,
  input  logic [FLD_W:0]   frame_lines_i,
  output logic             irq_o
);

  localparam int PW = FLD_W + 1;

  logic          enabled, match, fire_d;
  logic          match_q, irq_q;
  logic [PW-1:0] phys_tgt;

  always_comb begin
    phys_tgt = {tgt_i, odd_i};
    enabled  = {tgt_i, 1'b0} < frame_lines_i;
    match    = enabled && (dot_i == '0) && (line_i == phys_tgt);
    fire_d   = match && !match_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      match_q <= match;
      irq_q   <= fire_d;
    end
  end

  assign irq_o = irq_q;

  // R2: a pulse follows a dot-zero position whose parity matches the field
  p_vdot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(dot_i) == '0) && ($past(line_i[0]) == $past(odd_i)));

  // R10: one clock wide
  p_vsingle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R3: the fired target was inside the frame
  p_venable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(line_i) < $past(frame_lines_i)));

endmodule

// File: rtl/scanirq_hunit.sv
module scanirq_hunit
  import scanirq_pkg::*;
#(
  parameter int FLD_W = 10,
  parameter int DOT_W = 11,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [FLD_W-1:0] load_line_i,
  input  hmode_e           load_mode_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [FLD_W:0]   line_i,
  input  logic [DOT_W-1:0] dot_i,
  input  logic             odd_i,
  input  logic [FLD_W:0]   frame_lines_i,
  input  logic [DOT_W-1:0] last_dot_i,
  output logic             irq_o
);

  localparam int TW = FLD_W + 1;
  localparam int CW = (OFF_W + 1 > DOT_W) ? OFF_W + 1 : DOT_W;

  logic [TW-1:0] tgt_q, tgt_d, step_q, step_d, half, cur_fl;
  logic          rep_q, rep_d, pend_q, pend_d;
  logic          match_q, irq_q;
  logic          enabled, line_hit, dot_hit, match, fire, upd_en;
  logic [CW-1:0] dot_raw, dot_lim, dot_tgt;

  // Dot position, clamped to the last dot of the line
  always_comb begin
    dot_raw = CW'({off_i, 1'b0});
    dot_lim = CW'(last_dot_i);
    dot_tgt = (dot_raw > dot_lim) ? dot_lim : dot_raw;
  end

  always_comb begin
    half     = {1'b0, frame_lines_i[TW-1:1]};
    cur_fl   = {1'b0, line_i[TW-1:1]};
    enabled  = {tgt_q, 1'b0} < {1'b0, frame_lines_i};
    line_hit = {tgt_q, odd_i} == {1'b0, line_i};
    dot_hit  = CW'(dot_i) == dot_tgt;
    match    = !pend_q && enabled && line_hit && dot_hit;
    fire     = match && !match_q;
  end

  // Target sequencing: a write wins over an advance, an advance starts a wrap
  always_comb begin
    tgt_d  = tgt_q;
    step_d = step_q;
    rep_d  = rep_q;
    pend_d = pend_q;
    if (load_i) begin
      if (is_repeat(load_mode_i)) begin
        step_d = (load_mode_i == HM_EVERY_LINE) ? TW'(1) : {1'b0, load_line_i};
        tgt_d  = cur_fl + step_d;
        rep_d  = 1'b1;
        pend_d = 1'b1;
      end else begin
        tgt_d  = {1'b0, load_line_i};
        rep_d  = 1'b0;
        pend_d = 1'b0;
      end
    end else if (fire && rep_q) begin
      tgt_d  = tgt_q + step_q;
      pend_d = 1'b1;
    end else if (pend_q) begin
      if ((half != '0) && (tgt_q > half)) tgt_d = tgt_q - half;
      else pend_d = 1'b0;
    end
  end

  assign upd_en = load_i || (fire && rep_q) || pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      step_q <= '0;
      rep_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      tgt_q  <= tgt_d;
      step_q <= step_d;
      rep_q  <= rep_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      match_q <= match;
      irq_q   <= fire;
    end
  end

  assign irq_o = irq_q;

  // R5: pulse follows the clamped dot position
  p_hdot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (CW'($past(dot_i)) == $past(dot_tgt)));

  // R9: no pulse out of a cycle that was still wrapping
  p_no_fire_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(pend_q));

  // R9: a settled repeating target never exceeds half the frame
  p_wrap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_q && !pend_q && (half != '0)) |-> (tgt_q <= half));

  // R10: one clock wide
  p_hsingle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

endmodule

// File: rtl/scanirq_gen.sv
module scanirq_gen
  import scanirq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FLD_W  = 10,
  parameter int DOT_W  = 11,
  parameter int OFF_W  = 10,
  parameter int V_ADDR = 0,
  parameter int H_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [FLD_W:0]    line_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              odd_field_i,
  input  logic [FLD_W:0]    frame_lines_i,
  input  logic [DOT_W-1:0]  last_dot_i,
  output logic              irq_va_o,
  output logic              irq_vb_o,
  output logic              irq_h_o
);

  localparam int NUM_V = 2;

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic [FLD_W-1:0] vtgt [NUM_V];
  logic [NUM_V-1:0] virq;
  logic [OFF_W-1:0] hoff;
  logic             h_load;
  logic [FLD_W-1:0] h_line;
  hmode_e           h_mode;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  scanirq_regs #(
    .ADDR_W(ADDR_W), .V_ADDR(V_ADDR), .H_ADDR(H_ADDR),
    .FLD_W(FLD_W), .OFF_W(OFF_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .va_o     (vtgt[0]),
    .vb_o     (vtgt[1]),
    .hoff_o   (hoff),
    .h_load_o (h_load),
    .h_line_o (h_line),
    .h_mode_o (h_mode)
  );

  for (genvar gi = 0; gi < NUM_V; gi++) begin : g_vcmp
    scanirq_vcmp #(.FLD_W(FLD_W), .DOT_W(DOT_W)) u_vcmp (
      .clk           (clk),
      .rst_n         (rst_n_s),
      .tgt_i         (vtgt[gi]),
      .line_i        (line_i),
      .dot_i         (dot_i),
      .odd_i         (odd_field_i),
      .frame_lines_i (frame_lines_i),
      .irq_o         (virq[gi])
    );
  end

  scanirq_hunit #(.FLD_W(FLD_W), .DOT_W(DOT_W), .OFF_W(OFF_W)) u_hunit (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .load_i        (h_load),
    .load_line_i   (h_line),
    .load_mode_i   (h_mode),
    .off_i         (hoff),
    .line_i        (line_i),
    .dot_i         (dot_i),
    .odd_i         (odd_field_i),
    .frame_lines_i (frame_lines_i),
    .last_dot_i    (last_dot_i),
    .irq_o         (irq_h_o)
  );

  assign irq_va_o = virq[0];
  assign irq_vb_o = virq[1];

  // R12: quiet while the internal reset is held
  always_comb begin
    if (!rst_n_s) begin
      p_reset_quiet_r12: assert (!irq_va_o && !irq_vb_o && !irq_h_o);
    end
  end

endmodule

// File: tb/scanirq_gen_test.sv
`timescale 1ns/1ps
module scanirq_gen_test;
  localparam int FLD_W = 10;
  localparam int DOT_W = 11;
  localparam int ADDR_W = 4;
  localparam int FRAME = 21;
  localparam int LAST = 7;
  localparam int HALF = FRAME / 2;
  localparam int FRAME_CYC = FRAME * (LAST + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, wr_en, odd_field_i;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [FLD_W:0] line_i, frame_lines_i;
  logic [DOT_W-1:0] dot_i, last_dot_i;
  logic irq_va_o, irq_vb_o, irq_h_o;

  scanirq_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_i(line_i), .dot_i(dot_i), .odd_field_i(odd_field_i),
    .frame_lines_i(frame_lines_i), .last_dot_i(last_dot_i),
    .irq_va_o(irq_va_o), .irq_vb_o(irq_vb_o), .irq_h_o(irq_h_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R12";

  int r_line, r_dot; bit r_odd;
  int m_va, m_vb, m_ht, m_hstep, m_hoff; bit m_hrep;
  bit mp_va, mp_vb, mp_h, e_va, e_vb, e_h, wrote;

  function automatic int wrap(int t);
    while (t > HALF && HALF != 0) t -= HALF;
    return t;
  endfunction

  function automatic bit vmatch(int n);
    return (2 * n < FRAME) && (r_dot == 0) && (r_line == 2 * n + int'(r_odd));
  endfunction

  function automatic bit hmatch();
    int dt = 2 * m_hoff;
    if (dt > LAST) dt = LAST;
    return (2 * m_ht < FRAME) && (r_line == 2 * m_ht + int'(r_odd)) && (r_dot == dt);
  endfunction

  task automatic check1(bit act, bit exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b (raster line %0d dot %0d odd %0b)",
               tag, what, act, exp, r_line, r_dot, r_odd);
    end
  endtask

  task automatic load_h(logic [31:0] d);
    int mode = int'((d >> 12) & 3);
    int ln = int'(d & 1023);
    m_hoff = int'((d >> 16) & 1023);
    if (mode == 1 || mode == 2) begin
      m_hstep = (mode == 2) ? 1 : ln;
      m_hrep = 1;
      m_ht = wrap((r_line >> 1) + m_hstep);
    end else begin
      m_hrep = 0;
      m_ht = ln;
    end
  endtask

  // One clock: check the outputs for the previous position, present the next.
  task automatic step(bit stall = 0, bit we = 0, logic [ADDR_W-1:0] addr = '0,
                      logic [31:0] data = '0, bit on_hit = 0);
    bit mva, mvb, mh, do_wr;
    @(negedge clk);
    check1(irq_va_o, e_va, "irq_va");
    check1(irq_vb_o, e_vb, "irq_vb");
    check1(irq_h_o, e_h, "irq_h");
    if (!stall) begin
      r_dot++;
      if (r_dot > LAST) begin
        r_dot = 0; r_line++;
        if (r_line == FRAME) begin r_line = 0; r_odd = ~r_odd; end
      end
    end
    line_i = (FLD_W+1)'(r_line); dot_i = DOT_W'(r_dot); odd_field_i = r_odd;
    mva = vmatch(m_va); mvb = vmatch(m_vb); mh = hmatch();
    e_va = mva & ~mp_va; e_vb = mvb & ~mp_vb; e_h = mh & ~mp_h;
    mp_va = mva; mp_vb = mvb; mp_h = mh;
    do_wr = we && (!on_hit || ((addr == 1) ? e_h : e_va));
    wrote = do_wr;
    wr_en = do_wr; wr_addr = addr; wr_data = data;
    if (do_wr && addr == 1) load_h(data);
    else if (e_h && m_hrep) m_ht = wrap(m_ht + m_hstep);
    if (do_wr && addr == 0) begin
      m_va = int'((data >> 16) & 1023);
      m_vb = int'(data & 1023);
    end
  endtask

  task automatic wr_at_last(logic [ADDR_W-1:0] addr, logic [31:0] data);
    while (r_dot != LAST - 1) step();
    step(0, 1, addr, data);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    r_line = 5; r_dot = 3; r_odd = 0;
    line_i = 11'd5; dot_i = 11'd3; odd_field_i = 0;
    frame_lines_i = 11'(FRAME); last_dot_i = 11'(LAST);
    m_va = 0; m_vb = 0; m_ht = 0; m_hstep = 0; m_hoff = 0; m_hrep = 0;
    mp_va = 0; mp_vb = 0; mp_h = 0; e_va = 0; e_vb = 0; e_h = 0;

    // R12: reset state, including the synchronous release period
    tag = "R12";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 2) rst_n = 1;
      check1(irq_va_o, 0, "irq_va"); check1(irq_vb_o, 0, "irq_vb"); check1(irq_h_o, 0, "irq_h");
    end
    // zero targets fire at lines 0 and 1 after reset
    run(2 * FRAME_CYC);

    // R1 R2 R3: vertical sweep, junk bits outside both fields
    tag = "R1 R2 R3";
    for (int n = 0; n < 12; n++) begin
      int b = (n + 3) % 12;
      wr_at_last(0, 32'(((n << 16) | b)) | 32'hFC00_FC00);
      run(2 * FRAME_CYC);
    end

    // R4 R5 R6: fixed-target modes, every line and offset including the clamp
    tag = "R4 R5 R6";
    for (int md = 0; md < 2; md++) begin
      for (int ln = 0; ln < 11; ln++) begin
        for (int off = 0; off < 5; off++) begin
          int mode = (md == 0) ? 0 : 3;
          wr_at_last(1, 32'((off << 16) | (mode << 12) | ln) | 32'hFC00_CC00);
          run(2 * FRAME_CYC);
        end
      end
    end

    // R7 R9: every N lines, including N above half the frame
    tag = "R7 R9";
    for (int n = 1; n < 13; n++) begin
      wr_at_last(1, 32'((2 << 16) | (1 << 12) | n));
      run(4 * FRAME_CYC);
    end

    // R8: every line, line field content ignored
    tag = "R8";
    wr_at_last(1, 32'((3 << 16) | (2 << 12) | 7));
    run(4 * FRAME_CYC);

    // R10: held raster on matching positions gives one pulse each
    tag = "R10";
    wr_at_last(1, 32'((0 << 16) | (0 << 12) | 3));
    wr_at_last(0, 32'((3 << 16) | 5));
    run(3);
    r_line = 6; r_dot = 0; r_odd = 0;
    step(1);
    for (int i = 0; i < 5; i++) step(1);
    run(FRAME_CYC);
    r_line = 11; r_dot = 0; r_odd = 1;
    step(1);
    for (int i = 0; i < 5; i++) step(1);
    run(FRAME_CYC);

    // R11: writes landing exactly on a hit
    tag = "R11";
    wr_at_last(1, 32'((2 << 16) | (1 << 12) | 2));
    for (int i = 0; i < 4 * FRAME_CYC; i++) begin
      step(0, 1, 1, 32'((1 << 16) | (0 << 12) | 5), 1);
      if (wrote) break;
    end
    run(2 * FRAME_CYC);
    for (int i = 0; i < 4 * FRAME_CYC; i++) begin
      step(0, 1, 0, 32'((4 << 16) | 8), 1);
      if (wrote) break;
    end
    run(2 * FRAME_CYC);

    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule